// File: doc/BRIEF.md
# Multi-lane SPI master transfer engine

This block is the shifting core of an SPI master. It takes one command at a time from a simple valid/ready command port and either changes the slave-select line or moves one data word across the serial bus. Three line modes are available. The first is classic full-duplex, where one lane carries data out and another carries data in. The other two are half-duplex transfers that use two or four lanes in a single direction. Every one of the four lanes has its own output value, input value and output-enable, so an I/O ring can turn each pin around on its own.

The serial clock half-period, the clock polarity and phase, the slave-select polarity and three slave-select delays all come from static configuration inputs. These are the delay before the first clock edge, the hold time after the last edge and the minimum time the select stays inactive. Each command ends with a one-cycle done pulse. A read transfer also places the received word on the response port with a one-cycle valid strobe. Half-duplex operation exists only when the word width is 8 or 16. At any other width a multi-lane request runs as a full-duplex transfer.

Top module: `spi_lane_master`

## Requirements
- R1: After reset, cmd_ready is 1, lane_oe is 0000, done and rsp_valid are 0, and ss is at its inactive level.
- R2: Full-duplex (cmd_lanes = 0) sends the word MSB first on lane_out[0] and samples incoming bits from lane_in[1]. lane_oe is 0001 throughout, and a read returns the sampled word on rsp_data.
- R3: Dual-lane half-duplex (cmd_lanes = 1) moves 2 bits per serial clock, MSB pair first, with lane 0 carrying the lower bit of each pair. A write drives lane_oe = 0011.
- R4: Quad-lane half-duplex (cmd_lanes = 2) moves 4 bits per serial clock, MSB nibble first, with lane 0 carrying the lowest bit of each nibble. A write drives lane_oe = 1111.
- R5: A half-duplex read (cmd_read = 1) keeps lane_oe at 0000 for the whole transfer and assembles the word from the active lanes' inputs.
- R6: When DATA_W is neither 8 nor 16, cmd_lanes = 1 or 2 is executed as a full-duplex transfer.
- R7: Each serial clock half-period lasts cfg_clk_div+1 clock cycles. A transfer has DATA_W/L serial clock cycles, where L is 1, 2 or 4 lanes.
- R8: sclk rests at cfg_cpol between transfers. With cfg_cpha = 0, data is valid before the leading edge and sampled on it. With cfg_cpha = 1, data changes on the leading edge and is sampled on the trailing edge.
- R9: ss equals the internal select state when cfg_ss_active_high = 1 and its inverse when it is 0.
- R10: cmd_op = 1 (select) asserts ss, and its command finishes no sooner than cfg_ss_setup+1 cycles later. cmd_op = 2 (release) keeps ss asserted for at least cfg_ss_hold+1 cycles and then deasserts it. After deassertion the next command is not accepted for at least cfg_ss_gap+1 cycles.
- R11: Every command (cmd_op = 0 transfer, 1 select, 2 release) ends with a single-cycle done. rsp_valid pulses, together with done, only for a transfer with cmd_read = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase: 0 leading edge, 1 trailing edge |
| cfg_ss_active_high | input | 1 | Select polarity: 1 active-high, 0 active-low |
| cfg_clk_div | input | DIV_W | Half-period length minus one, in clock cycles |
| cfg_ss_setup | input | DLY_W | Delay after select before the command finishes |
| cfg_ss_hold | input | DLY_W | Delay held before releasing select |
| cfg_ss_gap | input | DLY_W | Minimum inactive time after release |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | 0 transfer, 1 select, 2 release |
| cmd_lanes | input | 2 | 0 full-duplex, 1 two lanes, 2 four lanes |
| cmd_read | input | 1 | Return received word; in half-duplex selects read direction |
| cmd_data | input | DATA_W | Word to send |
| done | output | 1 | One-cycle command completion |
| rsp_valid | output | 1 | Received word strobe |
| rsp_data | output | DATA_W | Received word |
| sclk | output | 1 | Serial clock |
| ss | output | 1 | Slave select |
| lane_in | input | 4 | Lane input values |
| lane_out | output | 4 | Lane output values |
| lane_oe | output | 4 | Lane output enables |

## Verification
The bench runs every combination of clock mode, lane mode, direction and two divider values with a bench-side slave. The slave launches and samples bits on the edges that the phase rule dictates, so a design that samples on the wrong edge, or shifts before the first edge in phase 1, returns a word displaced by one group. Separate checks catch lane order within a group being reversed, output-enables left on during a half-duplex read, and a wrong half-period or edge count. Slave-select windows are timed against the last and first clock edges to expose off-by-one counters. A 5-bit instance run in loopback exposes a width that wrongly allows multi-lane transfers, because its returned word would not match.

// File: rtl/spi_lane_pkg.sv
`timescale 1ns/1ps
package spi_lane_pkg;
  typedef enum logic [1:0] {
    LM_SINGLE = 2'd0,
    LM_DUAL   = 2'd1,
    LM_QUAD   = 2'd2
  } lane_mode_e;

  typedef enum logic [1:0] {
    OP_XFER    = 2'd0,
    OP_SELECT  = 2'd1,
    OP_RELEASE = 2'd2
  } cmd_op_e;

  function automatic logic [3:0] drive_mask(input lane_mode_e m);
    case (m)
      LM_DUAL: drive_mask = 4'b0011;
      LM_QUAD: drive_mask = 4'b1111;
      default: drive_mask = 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/spi_lane_clkgen.sv
`timescale 1ns/1ps
module spi_lane_clkgen #(
  parameter int DIV_W = 8,
  parameter int HW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  input  logic [HW-1:0]    nhalf,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             last_stb
);
  logic [DIV_W-1:0] dcnt;
  logic [HW-1:0]    hcnt;
  logic             edge_now;

  assign edge_now  = run && !start && (dcnt == '0);
  assign lead_stb  = edge_now && !hcnt[0];
  assign trail_stb = edge_now && hcnt[0];
  assign last_stb  = edge_now && (hcnt == nhalf - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b0;
      dcnt <= '0;
      hcnt <= '0;
    end else if (start) begin
      dcnt <= div;
      hcnt <= '0;
      sclk <= cpol;
    end else if (run) begin
      if (dcnt == '0) begin
        dcnt <= div;
        sclk <= ~sclk;
        hcnt <= hcnt + 1'b1;
      end else begin
        dcnt <= dcnt - 1'b1;
      end
    end else begin
      sclk <= cpol;
    end
  end

  AST_HALF_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (hcnt < nhalf)); // R7
endmodule

// File: rtl/spi_lane_shifter.sv
`timescale 1ns/1ps
module spi_lane_shifter
  import spi_lane_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  lane_mode_e        mode,
  input  logic              cpha,
  input  logic              lead_stb,
  input  logic              trail_stb,
  input  logic [3:0]        lane_in,
  output logic [3:0]        lane_out,
  output logic [DATA_W-1:0] rx_word
);
  localparam bit HALF_OK = (DATA_W == 8) || (DATA_W == 16);

  logic [DATA_W-1:0] tx_sh, rx_sh, tx_next, rx_next;
  logic              skip_first;
  logic              samp, adv;

  // Phase 1 launches on leading edges, but the first group is already loaded.
  assign samp = cpha ? trail_stb : lead_stb;
  assign adv  = cpha ? (lead_stb && !skip_first) : trail_stb;

  generate
    if (HALF_OK) begin : g_multi
      always_comb begin
        unique case (mode)
          LM_DUAL: begin
            tx_next  = {tx_sh[DATA_W-3:0], 2'b00};
            rx_next  = {rx_sh[DATA_W-3:0], lane_in[1:0]};
            lane_out = {2'b00, tx_sh[DATA_W-1:DATA_W-2]};
          end
          LM_QUAD: begin
            tx_next  = {tx_sh[DATA_W-5:0], 4'b0000};
            rx_next  = {rx_sh[DATA_W-5:0], lane_in};
            lane_out = tx_sh[DATA_W-1:DATA_W-4];
          end
          default: begin
            tx_next  = {tx_sh[DATA_W-2:0], 1'b0};
            rx_next  = {rx_sh[DATA_W-2:0], lane_in[1]};
            lane_out = {3'b000, tx_sh[DATA_W-1]};
          end
        endcase
      end
    end else begin : g_single
      always_comb begin
        tx_next  = {tx_sh[DATA_W-2:0], 1'b0};
        rx_next  = {rx_sh[DATA_W-2:0], lane_in[1]};
        lane_out = {3'b000, tx_sh[DATA_W-1]};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh      <= '0;
      rx_sh      <= '0;
      skip_first <= 1'b0;
    end else if (load) begin
      tx_sh      <= load_data;
      rx_sh      <= '0;
      skip_first <= 1'b1;
    end else begin
      if (adv)      tx_sh <= tx_next;
      if (samp)     rx_sh <= rx_next;
      if (lead_stb) skip_first <= 1'b0;
    end
  end

  assign rx_word = rx_sh;

  AST_PHASE1_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cpha && lead_stb && skip_first) |=> $stable(tx_sh)); // R8
endmodule

// File: rtl/spi_lane_ctrl.sv
`timescale 1ns/1ps
module spi_lane_ctrl
  import spi_lane_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8,
  parameter int HW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_lanes,
  input  logic              cmd_read,
  input  logic [DLY_W-1:0]  cfg_ss_setup,
  input  logic [DLY_W-1:0]  cfg_ss_hold,
  input  logic [DLY_W-1:0]  cfg_ss_gap,
  input  logic              last_stb,
  input  logic [DATA_W-1:0] rx_word,
  output logic              cmd_ready,
  output logic              start,
  output logic              run,
  output lane_mode_e        mode_q,
  output logic [HW-1:0]     nhalf,
  output logic [3:0]        lane_oe,
  output logic              ss_act,
  output logic              done,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam bit HALF_OK = (DATA_W == 8) || (DATA_W == 16);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_FINISH, ST_HOLD, ST_GAP
  } state_e;

  state_e           state;
  logic [DLY_W-1:0] cnt;
  logic             rd_q;
  lane_mode_e       mode_in;
  logic             accept;

  always_comb begin
    mode_in = LM_SINGLE;
    if (HALF_OK) begin
      if (cmd_lanes == 2'd1)      mode_in = LM_DUAL;
      else if (cmd_lanes == 2'd2) mode_in = LM_QUAD;
    end
  end

  always_comb begin
    case (mode_q)
      LM_DUAL: nhalf = HW'(DATA_W);
      LM_QUAD: nhalf = HW'(DATA_W / 2);
      default: nhalf = HW'(2 * DATA_W);
    endcase
  end

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && (cmd_op == 2'(OP_XFER));
  assign run       = (state == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      mode_q    <= LM_SINGLE;
      rd_q      <= 1'b0;
      lane_oe   <= 4'b0000;
      ss_act    <= 1'b0;
      done      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      done      <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            case (cmd_op)
              2'(OP_XFER): begin
                mode_q <= mode_in;
                rd_q   <= cmd_read;
                if (mode_in == LM_SINGLE) lane_oe <= 4'b0001;
                else if (cmd_read)        lane_oe <= 4'b0000;
                else                      lane_oe <= drive_mask(mode_in);
                state  <= ST_SHIFT;
              end
              2'(OP_SELECT): begin
                ss_act <= 1'b1;
                cnt    <= cfg_ss_setup;
                state  <= ST_SETUP;
              end
              2'(OP_RELEASE): begin
                cnt   <= cfg_ss_hold;
                state <= ST_HOLD;
              end
              default: begin
                rd_q  <= 1'b0;
                state <= ST_FINISH;
              end
            endcase
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (last_stb) state <= ST_FINISH;
        end
        ST_FINISH: begin
          done      <= 1'b1;
          rsp_valid <= rd_q;
          if (rd_q) rsp_data <= rx_word;
          lane_oe   <= 4'b0000;
          state     <= ST_IDLE;
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            ss_act <= 1'b0;
            cnt    <= cfg_ss_gap;
            state  <= ST_GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_RSP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> done); // R11
  AST_SS_STABLE_XFER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> $stable(ss_act)); // R10
  AST_READ_LANES_QUIET: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q != LM_SINGLE && rd_q) |-> (lane_oe == 4'b0000)); // R5
  AST_HALF_NEEDS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q != LM_SINGLE) |-> HALF_OK); // R6
endmodule

// File: rtl/spi_lane_master.sv
`timescale 1ns/1ps
module spi_lane_master
  import spi_lane_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_ss_active_high,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [DLY_W-1:0]  cfg_ss_setup,
  input  logic [DLY_W-1:0]  cfg_ss_hold,
  input  logic [DLY_W-1:0]  cfg_ss_gap,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_lanes,
  input  logic              cmd_read,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              done,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sclk,
  output logic              ss,
  input  logic [3:0]        lane_in,
  output logic [3:0]        lane_out,
  output logic [3:0]        lane_oe
);
  localparam int HW = $clog2(2 * DATA_W + 1);

  logic              start, run, lead_stb, trail_stb, last_stb, ss_act;
  lane_mode_e        mode_q;
  logic [HW-1:0]     nhalf;
  logic [DATA_W-1:0] rx_word;

  spi_lane_ctrl #(.DATA_W(DATA_W), .DLY_W(DLY_W), .HW(HW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_lanes(cmd_lanes), .cmd_read(cmd_read), .cfg_ss_setup(cfg_ss_setup),
    .cfg_ss_hold(cfg_ss_hold), .cfg_ss_gap(cfg_ss_gap), .last_stb(last_stb),
    .rx_word(rx_word), .cmd_ready(cmd_ready), .start(start), .run(run),
    .mode_q(mode_q), .nhalf(nhalf), .lane_oe(lane_oe), .ss_act(ss_act),
    .done(done), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  spi_lane_clkgen #(.DIV_W(DIV_W), .HW(HW)) u_clkgen (
    .clk(clk), .rst(rst), .start(start), .run(run), .cpol(cfg_cpol),
    .div(cfg_clk_div), .nhalf(nhalf), .sclk(sclk), .lead_stb(lead_stb),
    .trail_stb(trail_stb), .last_stb(last_stb)
  );

  spi_lane_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst(rst), .load(start), .load_data(cmd_data), .mode(mode_q),
    .cpha(cfg_cpha), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .lane_in(lane_in), .lane_out(lane_out), .rx_word(rx_word)
  );

  assign ss = cfg_ss_active_high ? ss_act : ~ss_act;

  AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && $past(cmd_ready) && !$past(rst) && $stable(cfg_cpol))
      |-> (sclk == cfg_cpol)); // R8
endmodule

// File: tb/spi_lane_master_bench.sv
`timescale 1ns/1ps
module spi_lane_master_bench;
  localparam int DW = 8;
  localparam int OW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cfg_cpol = 0, cfg_cpha = 0, cfg_ss_active_high = 0;
  logic [7:0]    cfg_clk_div = 0, cfg_ss_setup = 0, cfg_ss_hold = 0, cfg_ss_gap = 0;
  logic          cmd_valid = 0, cmd_read = 0;
  logic [1:0]    cmd_op = 0, cmd_lanes = 0;
  logic [DW-1:0] cmd_data = 0;
  logic          cmd_ready, done, rsp_valid, sclk, ss;
  logic [DW-1:0] rsp_data;
  logic [3:0]    lane_in, lane_out, lane_oe;

  spi_lane_master #(.DATA_W(DW)) u_spi_lane_master (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_ss_active_high(cfg_ss_active_high), .cfg_clk_div(cfg_clk_div),
    .cfg_ss_setup(cfg_ss_setup), .cfg_ss_hold(cfg_ss_hold), .cfg_ss_gap(cfg_ss_gap),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_lanes(cmd_lanes), .cmd_read(cmd_read), .cmd_data(cmd_data),
    .done(done), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sclk(sclk),
    .ss(ss), .lane_in(lane_in), .lane_out(lane_out), .lane_oe(lane_oe)
  );

  // 5-bit instance with lane 0 looped back to lane 1
  logic          o_valid = 0, o_read = 0;
  logic [1:0]    o_op = 0, o_lanes = 0;
  logic [OW-1:0] o_data = 0;
  logic          o_ready, o_done, o_rsp_valid, o_sclk, o_ss;
  logic [OW-1:0] o_rsp_data;
  logic [3:0]    o_lane_in, o_lane_out, o_lane_oe;
  assign o_lane_in = {2'b00, o_lane_out[0], 1'b0};

  spi_lane_master #(.DATA_W(OW)) u_odd (
    .clk(clk), .rst(rst), .cfg_cpol(1'b0), .cfg_cpha(1'b0),
    .cfg_ss_active_high(1'b0), .cfg_clk_div(8'd0),
    .cfg_ss_setup(8'd0), .cfg_ss_hold(8'd0), .cfg_ss_gap(8'd0),
    .cmd_valid(o_valid), .cmd_ready(o_ready), .cmd_op(o_op),
    .cmd_lanes(o_lanes), .cmd_read(o_read), .cmd_data(o_data),
    .done(o_done), .rsp_valid(o_rsp_valid), .rsp_data(o_rsp_data), .sclk(o_sclk),
    .ss(o_ss), .lane_in(o_lane_in), .lane_out(o_lane_out), .lane_oe(o_lane_oe)
  );

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Slave model state
  int            cyc = 0, edges = 0, lead_cnt = 0, g = 0, lanes_tb = 1;
  int            last_edge_cyc = 0, first_edge_cyc = 0, hp_min = 0, hp_max = 0;
  int            ss_on_cyc = 0, ss_off_cyc = 0, rsp_cnt = 0, o_rsp_cnt = 0;
  logic          prev_sclk = 0, prev_ss_act = 0, oe_bad = 0;
  logic [3:0]    exp_oe = 0, o_oe_or = 0;
  logic [DW-1:0] cap = 0, sw = 0, rsp_seen = 0, shifted;
  logic [OW-1:0] o_rsp_seen = 0;

  always_comb begin
    shifted = sw << (g * lanes_tb);
    case (lanes_tb)
      2:       lane_in = {2'b00, shifted[DW-1:DW-2]};
      4:       lane_in = shifted[DW-1:DW-4];
      default: lane_in = {2'b11, shifted[DW-1], 1'b1};
    endcase
  end

  always @(negedge clk) begin
    logic lead, ssa;
    cyc++;
    if (!rst) begin
      if (sclk !== prev_sclk) begin
        lead = (sclk != cfg_cpol);
        if (edges > 0) begin
          if (cyc - last_edge_cyc < hp_min) hp_min = cyc - last_edge_cyc;
          if (cyc - last_edge_cyc > hp_max) hp_max = cyc - last_edge_cyc;
        end else first_edge_cyc = cyc;
        last_edge_cyc = cyc;
        edges++;
        if (lane_oe !== exp_oe) oe_bad = 1;
        if (cfg_cpha ? !lead : lead) begin
          case (lanes_tb)
            2:       cap = {cap[DW-3:0], lane_out[1:0]};
            4:       cap = {cap[DW-5:0], lane_out};
            default: cap = {cap[DW-2:0], lane_out[0]};
          endcase
        end
        if (cfg_cpha ? (lead && lead_cnt > 0) : !lead) g++;
        if (lead) lead_cnt++;
      end
      ssa = cfg_ss_active_high ? ss : !ss;
      if (ssa && !prev_ss_act) ss_on_cyc = cyc;
      if (!ssa && prev_ss_act) ss_off_cyc = cyc;
      prev_ss_act = ssa;
      if (rsp_valid) begin rsp_cnt++; rsp_seen = rsp_data; end
      if (o_rsp_valid) begin o_rsp_cnt++; o_rsp_seen = o_rsp_data; end
      o_oe_or = o_oe_or | o_lane_oe;
    end
    prev_sclk = sclk;
  end

  task automatic send(input int op, input int lanes, input bit rd, input logic [DW-1:0] d);
    int t;
    while (!cmd_ready) @(negedge clk);
    cmd_op = 2'(op); cmd_lanes = 2'(lanes); cmd_read = rd; cmd_data = d; cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic model_clear();
    edges = 0; lead_cnt = 0; g = 0; cap = 0; oe_bad = 0;
    hp_min = 1000000; hp_max = 0;
  endtask

  task automatic do_xfer(input int lanes, input bit rd, input int cp, input int div,
                         input logic [DW-1:0] d, input logic [DW-1:0] slave_w);
    int r0, nl;
    string tag;
    cfg_cpol = cp[1]; cfg_cpha = cp[0]; cfg_clk_div = 8'(div);
    nl = (lanes == 0) ? 1 : (lanes == 1) ? 2 : 4;
    tag = (lanes == 0) ? "R2" : (lanes == 1) ? "R3" : "R4";
    if (lanes != 0 && rd) tag = {tag, " R5"};
    exp_oe = (lanes == 0) ? 4'b0001 : rd ? 4'b0000 : (lanes == 1) ? 4'b0011 : 4'b1111;
    repeat (3) @(negedge clk);
    lanes_tb = nl; sw = slave_w;
    model_clear();
    r0 = rsp_cnt;
    send(0, lanes, rd, d);
    @(negedge clk);
    check(edges == 2 * DW / nl, $sformatf("R7 %s edges cp%0d", tag, cp), edges, 2 * DW / nl);
    check(hp_min == div + 1 && hp_max == div + 1,
          $sformatf("R7 %s half-period cp%0d div%0d", tag, cp, div), hp_max, div + 1);
    check(!oe_bad, $sformatf("%s lane_oe cp%0d", tag, cp), lane_oe, exp_oe);
    if (!(lanes != 0 && rd))
      check(cap == d, $sformatf("%s R8 sent word cp%0d", tag, cp), cap, d);
    if (rd)
      check(rsp_cnt == r0 + 1 && rsp_seen == slave_w,
            $sformatf("%s R8 R11 received word cp%0d", tag, cp), rsp_seen, slave_w);
    else
      check(rsp_cnt == r0, $sformatf("R11 %s no response on write", tag), rsp_cnt - r0, 0);
    check(sclk == cfg_cpol && lane_oe == 4'b0000,
          $sformatf("R8 idle level cp%0d", cp), sclk, cfg_cpol);
  endtask

  task automatic finish_sim();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_sim();
  end

  initial begin
    int it, on1, t;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state, active-low select
    check(cmd_ready == 1 && lane_oe == 0, "R1 ready and enables", {cmd_ready, lane_oe}, 5'b10000);
    check(done == 0 && rsp_valid == 0, "R1 no strobes", {done, rsp_valid}, 0);
    check(ss == 1, "R1 R9 select inactive low-active", ss, 1);

    it = 0;
    for (int cp = 0; cp < 4; cp++)
      for (int lanes = 0; lanes < 3; lanes++)
        for (int rd = 0; rd < 2; rd++)
          for (int dv = 0; dv < 2; dv++) begin
            do_xfer(lanes, rd[0], cp, dv * 2, DW'(8'hA5 ^ (it * 37)), DW'(8'h3C + it * 29));
            it++;
          end

    // R9 R10 select timing, active-high
    cfg_cpol = 0; cfg_cpha = 0; cfg_clk_div = 1;
    cfg_ss_active_high = 1; cfg_ss_setup = 3; cfg_ss_hold = 4; cfg_ss_gap = 5;
    repeat (3) @(negedge clk);
    check(ss == 0, "R9 inactive active-high", ss, 0);
    exp_oe = 4'b0001; lanes_tb = 1; sw = 8'h5A;
    send(1, 0, 0, 0);
    check(ss == 1, "R9 select asserted active-high", ss, 1);
    on1 = ss_on_cyc;
    model_clear();
    send(0, 0, 0, 8'hC3);
    send(2, 0, 0, 0);
    @(negedge clk);
    check(ss == 0, "R10 release deasserts", ss, 0);
    check(first_edge_cyc - on1 >= 4 && first_edge_cyc - on1 <= 8,
          "R10 setup window", first_edge_cyc - on1, 4);
    check(ss_off_cyc - last_edge_cyc >= 5 && ss_off_cyc - last_edge_cyc <= 8,
          "R10 hold window", ss_off_cyc - last_edge_cyc, 5);
    send(1, 0, 0, 0);
    check(ss_on_cyc - ss_off_cyc >= 6 && ss_on_cyc - ss_off_cyc <= 9,
          "R10 gap window", ss_on_cyc - ss_off_cyc, 6);
    send(2, 0, 0, 0);
    @(negedge clk);
    // R9 active-low select
    cfg_ss_active_high = 0;
    @(negedge clk);
    prev_ss_act = 0;
    send(1, 0, 0, 0);
    check(ss == 0, "R9 select asserted active-low", ss, 0);
    send(2, 0, 0, 0);
    @(negedge clk);
    check(ss == 1, "R9 release active-low", ss, 1);

    // R6 odd width: quad request runs full-duplex in loopback
    o_oe_or = 0;
    while (!o_ready) @(negedge clk);
    o_op = 0; o_lanes = 2; o_read = 1; o_data = 5'b10110; o_valid = 1;
    @(posedge clk);
    @(negedge clk);
    o_valid = 0;
    t = 0;
    while (!o_done && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    check(o_rsp_cnt == 1 && o_rsp_seen == 5'b10110, "R6 odd width loopback word",
          o_rsp_seen, 5'b10110);
    check(o_oe_or == 4'b0001, "R6 odd width enables", o_oe_or, 4'b0001);

    finish_sim();
  end
endmodule